// File: doc/BRIEF.md
# Serial Mouse Packet Encoder with Receive Queue

This block turns mouse activity into the five-byte packet format spoken by classic three-button serial mice and stores the bytes in a circular receive queue. A serial channel drains that queue one byte at a time. Each event is a one-cycle strobe that carries three button levels and signed X and Y movement values. The encoder writes the packet into the queue, one byte per clock.

The first byte is a sync byte with active-low button bits. The second byte is the X movement and the third is the negated Y movement, each clamped to ±127. Two zero bytes close the packet. An event that arrives while a packet is still being written is held in a single slot and written straight after the current packet. A newer event replaces the one in that slot. The queue drops bytes that arrive while it is full. A synchronous clear empties the queue.

Top module: `mouse_pkt_queue`

## Requirements
- R1: The first byte of a packet has bit 7 set and bits 6..3 clear. With no button pressed its value is 0x87.
- R2: A pressed left button clears bit 2 of the first byte, the middle button clears bit 1 and the right button clears bit 0. The buttons act independently of each other.
- R3: The second byte is the X movement clamped to -127..+127, in 8-bit two's complement. Any X above 127 gives 0x7F and any X below -127 gives 0x81, so 0x80 never appears.
- R4: The third byte is the arithmetic negation of the Y movement, clamped in the same way. The most negative input Y gives 0x7F.
- R5: Bytes four and five are 0x00. The bytes enter the queue in the order first, X, Y, zero, zero, one per clock. The first byte is written on the clock edge after the edge that captures the strobe.
- R6: The queue holds DEPTH (default 256) bytes and hands them out in first-in first-out order. A byte written while the queue holds DEPTH bytes is dropped, and the bytes already stored are kept.
- R7: `rd_data` shows the oldest stored byte without removing it, and `rd_en` removes it. When the queue is empty, `rd_data` is 0x00 and `data_avail` is low. `data_avail` stays high after a read while any byte remains.
- R8: A high `clr` on a clock edge empties the queue. It also drops any packet still being written and any held event.
- R9: An event that arrives while a packet is being written is held and written directly after that packet. A further event that arrives before then replaces the held one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous queue and encoder clear |
| evt_valid | input | 1 | One-cycle mouse event strobe |
| btn_left | input | 1 | Left button pressed (active high) |
| btn_mid | input | 1 | Middle button pressed (active high) |
| btn_right | input | 1 | Right button pressed (active high) |
| move_x | input | MOVE_W | Signed X movement |
| move_y | input | MOVE_W | Signed Y movement |
| rd_en | input | 1 | Remove the head byte |
| rd_data | output | 8 | Head byte, 0x00 when empty |
| data_avail | output | 1 | Queue holds at least one byte |

## Verification
A wrong count or pointer in the queue shows at the ports at once. `data_avail` disagrees with the number of bytes stored, or the very next read returns a byte from the wrong place. A fault in the byte index or the held-event slot shows as packets that are shifted, duplicated or merged. Those faults become visible within the five reads that drain a packet. A clamp or negation error changes only the second or third byte, and only for movements at or beyond ±127. For that reason the stimulus drives values at, just past and far past both limits.

// File: rtl/mouse_pkt_queue.sv
module mouse_pkt_queue #(
  parameter int DEPTH  = 256,
  parameter int MOVE_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     evt_valid,
  input  logic                     btn_left,
  input  logic                     btn_mid,
  input  logic                     btn_right,
  input  logic signed [MOVE_W-1:0] move_x,
  input  logic signed [MOVE_W-1:0] move_y,
  input  logic                     rd_en,
  output logic [7:0]               rd_data,
  output logic                     data_avail
);
  localparam int AW      = $clog2(DEPTH);
  localparam int CW      = AW + 1;
  localparam int PKT_LEN = 5;
  localparam int IW      = 3;

  function automatic logic [7:0] sat8(input logic signed [MOVE_W:0] v);
    if (v > 127)       return 8'h7F;
    else if (v < -127) return 8'h81;
    else               return v[7:0];
  endfunction

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          busy, held_v;
  logic [IW-1:0] idx;
  logic [23:0]   cur_pkt, held_pkt, new_pkt;
  logic [7:0]    wr_byte;
  logic          push, pop, finishing;
  logic signed [MOVE_W:0] x_ext, y_neg;

  assign x_ext   = {move_x[MOVE_W-1], move_x};
  assign y_neg   = -{move_y[MOVE_W-1], move_y};
  assign new_pkt = {1'b1, 4'b0000, ~btn_left, ~btn_mid, ~btn_right, sat8(x_ext), sat8(y_neg)};

  always_comb begin
    case (idx)
      3'd0:    wr_byte = cur_pkt[23:16];
      3'd1:    wr_byte = cur_pkt[15:8];
      3'd2:    wr_byte = cur_pkt[7:0];
      default: wr_byte = 8'h00;
    endcase
  end

  assign push       = busy && (count != CW'(DEPTH));
  assign pop        = rd_en && (count != '0);
  assign finishing  = !busy || (idx == IW'(PKT_LEN - 1));
  assign data_avail = (count != '0);
  assign rd_data    = data_avail ? mem[rptr] : 8'h00;

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wptr] <= wr_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      busy     <= 1'b0;
      held_v   <= 1'b0;
      idx      <= '0;
      cur_pkt  <= '0;
      held_pkt <= '0;
    end else if (clr) begin
      wptr   <= '0;
      rptr   <= '0;
      count  <= '0;
      busy   <= 1'b0;
      held_v <= 1'b0;
      idx    <= '0;
    end else begin
      if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
      if (finishing) begin
        idx <= '0;
        if (held_v) begin
          cur_pkt <= held_pkt;
          busy    <= 1'b1;
          held_v  <= evt_valid;
          if (evt_valid) held_pkt <= new_pkt;
        end else if (evt_valid) begin
          cur_pkt <= new_pkt;
          busy    <= 1'b1;
        end else begin
          busy <= 1'b0;
        end
      end else begin
        idx <= idx + 1'b1;
        if (evt_valid) begin
          held_pkt <= new_pkt;
          held_v   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mouse_pkt_queue_chk.sv
module mouse_pkt_queue_chk #(
  parameter int DEPTH = 256
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       clr,
  input logic                       rd_en,
  input logic                       data_avail,
  input logic                       busy,
  input logic [2:0]                 idx,
  input logic [7:0]                 wr_byte,
  input logic [$clog2(DEPTH):0]     count
);
  AST_SYNC_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idx == 3'd0) |-> (wr_byte[7:3] == 5'b10000)); // R1

  AST_X_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idx == 3'd1) |-> (wr_byte != 8'h80)); // R3

  AST_Y_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idx == 3'd2) |-> (wr_byte != 8'h80)); // R4

  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idx >= 3'd3) |-> (wr_byte == 8'h00)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= ($clog2(DEPTH) + 1)'(DEPTH)); // R6

  AST_AVAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (data_avail && !rd_en && !clr) |=> data_avail); // R7

  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !data_avail); // R8
endmodule

bind mouse_pkt_queue mouse_pkt_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .rd_en(rd_en), .data_avail(data_avail),
  .busy(busy), .idx(idx), .wr_byte(wr_byte), .count(count)
);

// File: tb/tb_mouse_pkt_queue.sv
module tb_mouse_pkt_queue;
  localparam int DEPTH = 256;

  logic clk = 0, rst_n = 0, clr = 0, evt_valid = 0;
  logic btn_left = 0, btn_mid = 0, btn_right = 0, rd_en = 0;
  logic signed [15:0] move_x = 0, move_y = 0;
  logic [7:0] rd_data;
  logic data_avail;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  logic [7:0] mq [DEPTH];
  int mh = 0, mt = 0, mc = 0;

  mouse_pkt_queue #(.DEPTH(DEPTH), .MOVE_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .evt_valid(evt_valid),
    .btn_left(btn_left), .btn_mid(btn_mid), .btn_right(btn_right),
    .move_x(move_x), .move_y(move_y), .rd_en(rd_en),
    .rd_data(rd_data), .data_avail(data_avail)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected <150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [7:0] sat(int v);
    if (v > 127) return 8'h7F;
    if (v < -127) return 8'h81;
    return v[7:0];
  endfunction

  function automatic logic [7:0] hdr(bit l, bit m, bit r);
    return 8'h87 ^ {5'b0, l, m, r};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic mpush(logic [7:0] b);
    if (mc < DEPTH) begin
      mq[mt] = b;
      mt = (mt + 1) % DEPTH;
      mc++;
    end
  endtask

  task automatic model_pkt(bit l, bit m, bit r, logic signed [15:0] x, logic signed [15:0] y);
    mpush(hdr(l, m, r));
    mpush(sat(int'(x)));
    mpush(sat(-int'(y)));
    mpush(8'h00);
    mpush(8'h00);
  endtask

  task automatic drive_evt(bit l, bit m, bit r, logic signed [15:0] x, logic signed [15:0] y);
    @(negedge clk);
    evt_valid = 1; btn_left = l; btn_mid = m; btn_right = r; move_x = x; move_y = y;
  endtask

  task automatic send(string req, bit l, bit m, bit r, logic signed [15:0] x, logic signed [15:0] y);
    drive_evt(l, m, r, x, y);
    @(negedge clk);
    evt_valid = 0;
    model_pkt(l, m, r, x, y);
    repeat (6) @(negedge clk);
  endtask

  task automatic read_one(string req);
    logic [7:0] e;
    @(negedge clk);
    check({req, " avail"}, {7'b0, data_avail}, {7'b0, mc != 0});
    e = (mc != 0) ? mq[mh] : 8'h00;
    check(req, rd_data, e);
    if (mc != 0) begin
      mh = (mh + 1) % DEPTH;
      mc--;
    end
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic drain(string req);
    int n = mc;
    for (int i = 0; i < n; i++) read_one(req);
    read_one({req, " R7 empty"});
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1;
    @(negedge clk);
    clr = 0;
    mh = 0; mt = 0; mc = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R7 reset avail", {7'b0, data_avail}, 8'h00);
    check("R7 reset data", rd_data, 8'h00);

    // R1 R2 buttons
    send("R1", 0, 0, 0, 16'sd0, 16'sd0);
    send("R2", 1, 0, 0, 16'sd5, -16'sd5);
    send("R2", 0, 1, 0, 16'sd1, 16'sd1);
    send("R2", 0, 0, 1, -16'sd1, 16'sd0);
    send("R2", 1, 1, 1, 16'sd0, 16'sd0);
    drain("R1 R2 R5");

    // R3 R4 clamp corners
    send("R3", 0, 0, 0, 16'sd127, 16'sd127);
    send("R3", 0, 0, 0, 16'sd128, -16'sd128);
    send("R3", 0, 0, 0, -16'sd127, -16'sd127);
    send("R3", 0, 0, 0, -16'sd128, 16'sd128);
    send("R4", 0, 0, 0, -16'sd32768, -16'sd32768);
    send("R4", 0, 0, 0, 16'sd32767, 16'sd32767);
    drain("R3 R4");

    // R5 timing: first byte visible one edge after capture
    drive_evt(0, 1, 0, 16'sd3, 16'sd4);
    @(negedge clk);
    evt_valid = 0;
    check("R5 no byte at capture edge", {7'b0, data_avail}, 8'h00);
    @(negedge clk);
    check("R5 byte after next edge", {7'b0, data_avail}, 8'h01);
    model_pkt(0, 1, 0, 16'sd3, 16'sd4);
    repeat (6) @(negedge clk);
    drain("R5");

    // R9 held event and replacement
    drive_evt(1, 0, 0, 16'sd10, 16'sd20);
    drive_evt(0, 1, 0, 16'sd30, 16'sd40);
    drive_evt(0, 0, 1, -16'sd50, -16'sd60);
    @(negedge clk);
    evt_valid = 0;
    model_pkt(1, 0, 0, 16'sd10, 16'sd20);
    model_pkt(0, 0, 1, -16'sd50, -16'sd60);
    repeat (14) @(negedge clk);
    drain("R9");

    // R9 event on the last byte of a packet
    drive_evt(0, 0, 0, 16'sd1, 16'sd2);
    @(negedge clk); evt_valid = 0;
    repeat (3) @(negedge clk);
    drive_evt(1, 1, 0, 16'sd7, 16'sd8);
    @(negedge clk); evt_valid = 0;
    model_pkt(0, 0, 0, 16'sd1, 16'sd2);
    model_pkt(1, 1, 0, 16'sd7, 16'sd8);
    repeat (12) @(negedge clk);
    drain("R9 tail");

    // Random
    for (int i = 0; i < 60; i++) begin
      logic signed [15:0] rx, ry;
      if ($urandom % 2) begin
        rx = 16'($urandom); ry = 16'($urandom);
      end else begin
        rx = 16'(int'($urandom % 401) - 200);
        ry = 16'(int'($urandom % 401) - 200);
      end
      send("R3 R4 random", 1'($urandom), 1'($urandom), 1'($urandom), rx, ry);
      if ($urandom % 3 == 0) drain("R6 R7 random");
    end
    drain("R6 R7 random");

    // R8 clear, including mid-packet
    send("R8", 0, 0, 0, 16'sd9, 16'sd9);
    send("R8", 1, 0, 0, 16'sd9, 16'sd9);
    do_clear();
    check("R8 avail after clear", {7'b0, data_avail}, 8'h00);
    check("R8 data after clear", rd_data, 8'h00);
    drive_evt(0, 0, 0, 16'sd2, 16'sd2);
    @(negedge clk); evt_valid = 0;
    clr = 1;
    @(negedge clk); clr = 0;
    repeat (8) @(negedge clk);
    check("R8 packet abandoned", {7'b0, data_avail}, 8'h00);

    // R6 overflow: 52 packets = 260 bytes, last 4 dropped
    for (int i = 0; i < 52; i++)
      send("R6", 1'(i), 1'(i >> 1), 0, 16'(i * 5 - 100), 16'(i));
    check("R6 full count", 8'(mc == DEPTH), 8'h01);
    drain("R6 overflow");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule